// File: doc/BRIEF.md
# Trimmed Counter With Match Interrupts

This block is a slow-rate time-of-day counter with three compare outputs. A one-cycle strobe, `tick`, marks each edge of a 32.768 kHz time base after it has been brought into the system clock domain. A 16-bit trim prescaler divides that strobe by a programmable amount before it advances a 32-bit count, and a bypass bit lets every strobe advance the count directly. Software can start and stop counting, load a new count and read the live count back.

Every writable register is double-buffered. A write lands in a staging copy and raises a busy flag. The staged value moves into the working register on the next `tick`, and the busy flag drops at that moment. This models a register that lives in the slow domain, and it lets software poll for completion. Three match registers each produce a one-cycle interrupt pulse when the count moves onto their value.

Top module: `trim_counter`

## Requirements
- R1: Register addresses are: 0 control, 1 trim (16 bits), 2 count load (reads as zero), 3 live count (read only), 4/5/6 match 0/1/2, 7 unused (reads as zero). Reads are combinational and return the applied (working) values, not the staged ones.
- R2: A write stores its data in a staging copy and sets the busy flag of that register. The flag is visible on the next cycle. The working value does not change until a `tick`. The busy flags sit in control bits 8 (control), 9 (trim), 10 (count load), 11/12/13 (match 0/1/2).
- R3: On a `tick` with a busy flag set and no write to the same register in that cycle, the staged value is applied and the flag clears. A write in the same cycle as a `tick` replaces the staged value and postpones the transfer to a later `tick`.
- R4: While the enable bit (control bit 0) is clear, the count does not advance.
- R5: With enable set and bypass clear, the count advances once every trim+1 ticks. The prescaler restarts from the new trim value whenever a trim write is applied, and it reloads from the trim value after each advance.
- R6: With enable and bypass (control bit 1) both set, every `tick` advances the count by one.
- R7: An applied count load replaces the count on its `tick` and takes priority over an advance on that same `tick`.
- R8: The count wraps from all-ones to zero.
- R9: `match_irq[i]` pulses high for exactly one cycle after a `tick` on which the count was advanced or loaded to a value equal to match register i. A match value applied on that same `tick` is the one compared. No further pulse is raised while the count stays unchanged.
- R10: Writes to address 3, to address 7, and to control bits other than 0 and 1 have no effect on any readable state.
- R11: After reset, all registers, busy flags, the count and the interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per time-base period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| match_irq | output | 3 | Per-match one-cycle interrupt pulses |

## Verification
Corruption of the staging or busy state shows up on the control read as a flag that is set or cleared at the wrong moment. It also shows as a working value that changes without a `tick`, and both are visible in the cycle after the offending edge. A prescaler that is off by one moves the count one `tick` early or late, so the live-count read diverges within trim+1 ticks. A wrong comparator or event term produces a missing, doubled or misplaced `match_irq` pulse in the very cycle the count lands on the match value. The reference model is compared on every clock, so each of these faults is reported at the first cycle it reaches a port.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    localparam int NUM_MATCH = 3;
    localparam int P_CTRL    = 0;
    localparam int P_TRIM    = 1;
    localparam int P_LOAD    = 2;
    localparam int P_MATCH0  = 3;
    localparam int NUM_PEND  = P_MATCH0 + NUM_MATCH;
    localparam int PEND_LSB  = 8;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_TRIM   = 3'd1,
        A_LOAD   = 3'd2,
        A_COUNT  = 3'd3,
        A_MATCH0 = 3'd4,
        A_MATCH1 = 3'd5,
        A_MATCH2 = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic bypass;
        logic enable;
    } ctrl_t;

    // address of the register behind each busy-flag slot
    function automatic logic [2:0] slot_addr(input int slot);
        if (slot == P_CTRL) return A_CTRL;
        if (slot == P_TRIM) return A_TRIM;
        if (slot == P_LOAD) return A_LOAD;
        return 3'(int'(A_MATCH0) + slot - P_MATCH0);
    endfunction

endpackage

// File: rtl/tcnt_regs.sv
module tcnt_regs
    import tcnt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                tick,
    input  logic                                wr_en,
    input  logic [2:0]                          wr_addr,
    input  logic [CNT_W-1:0]                    wr_data,
    output ctrl_t                               ctrl_q,
    output logic [TRIM_W-1:0]                   trim_q,
    output logic [TRIM_W-1:0]                   trim_stage,
    output logic                                trim_fire,
    output logic [CNT_W-1:0]                    load_stage,
    output logic                                load_fire,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     match_q,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     match_nxt,
    output logic [NUM_PEND-1:0]                 pend_q
);

    logic [NUM_PEND-1:0]            wsel;
    logic [NUM_PEND-1:0]            fire;
    ctrl_t                          ctrl_stage;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_stage;

    genvar k;
    generate
        for (k = 0; k < NUM_PEND; k++) begin : g_slot
            assign wsel[k] = wr_en && (wr_addr == slot_addr(k));
            assign fire[k] = tick && pend_q[k] && !wsel[k];

            a_r2_pend_set : assert property (@(posedge clk) disable iff (rst)
                wsel[k] |=> pend_q[k]);
            a_r3_pend_clear : assert property (@(posedge clk) disable iff (rst)
                (tick && pend_q[k] && !wsel[k]) |=> !pend_q[k]);
        end
        for (k = 0; k < NUM_MATCH; k++) begin : g_mnext
            assign match_nxt[k] = fire[P_MATCH0+k] ? match_stage[k] : match_q[k];
        end
    endgenerate

    assign trim_fire = fire[P_TRIM];
    assign load_fire = fire[P_LOAD];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            ctrl_stage  <= '0;
            ctrl_q      <= '0;
            trim_stage  <= '0;
            trim_q      <= '0;
            load_stage  <= '0;
            match_stage <= '0;
            match_q     <= '0;
        end else begin
            for (int s = 0; s < NUM_PEND; s++) begin
                if (wsel[s])      pend_q[s] <= 1'b1;
                else if (fire[s]) pend_q[s] <= 1'b0;
            end
            if (wsel[P_CTRL]) ctrl_stage <= ctrl_t'(wr_data[1:0]);
            if (fire[P_CTRL]) ctrl_q     <= ctrl_stage;
            if (wsel[P_TRIM]) trim_stage <= wr_data[TRIM_W-1:0];
            if (fire[P_TRIM]) trim_q     <= trim_stage;
            if (wsel[P_LOAD]) load_stage <= wr_data;
            for (int m = 0; m < NUM_MATCH; m++) begin
                if (wsel[P_MATCH0+m]) match_stage[m] <= wr_data;
                if (fire[P_MATCH0+m]) match_q[m]     <= match_stage[m];
            end
        end
    end

    // R3: working trim only moves on an applied transfer
    a_r3_trim_hold : assert property (@(posedge clk) disable iff (rst)
        !(tick && pend_q[P_TRIM] && !wsel[P_TRIM]) |=> $stable(trim_q));

endmodule

// File: rtl/tcnt_prescale.sv
module tcnt_prescale
    import tcnt_pkg::*;
#(
    parameter int TRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ctrl_t             ctrl_q,
    input  logic [TRIM_W-1:0] trim_q,
    input  logic [TRIM_W-1:0] trim_stage,
    input  logic              trim_fire,
    output logic              adv
);

    logic [TRIM_W-1:0] left_q;
    logic              run;
    logic              expired;

    assign run     = tick && ctrl_q.enable;
    assign expired = (left_q == '0);
    assign adv     = run && (ctrl_q.bypass || expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trim_fire) begin
            left_q <= trim_stage;
        end else if (run && !ctrl_q.bypass) begin
            left_q <= expired ? trim_q : left_q - 1'b1;
        end
    end

    // R5: a divided tick counts down without advancing
    a_r5_countdown : assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl_q.bypass && !expired && !trim_fire)
            |=> (left_q == $past(left_q) - 1'b1));
    a_r5_reload : assert property (@(posedge clk) disable iff (rst)
        (run && !ctrl_q.bypass && expired && !trim_fire) |=> (left_q == $past(trim_q)));

endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            adv,
    input  logic                            load_fire,
    input  logic [CNT_W-1:0]                load_stage,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_nxt,
    output logic [CNT_W-1:0]                count_q,
    output logic [NUM_MATCH-1:0]            irq_q
);

    logic [CNT_W-1:0]     count_d;
    logic                 step;
    logic [NUM_MATCH-1:0] hit;

    assign step    = load_fire || adv;
    assign count_d = load_fire ? load_stage : (adv ? count_q + 1'b1 : count_q);

    genvar i;
    generate
        for (i = 0; i < NUM_MATCH; i++) begin : g_cmp
            assign hit[i] = step && (count_d == match_nxt[i]);

            // R9: pulses never last two cycles
            a_r9_one_cycle : assert property (@(posedge clk) disable iff (rst)
                irq_q[i] |=> !irq_q[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            irq_q   <= '0;
        end else begin
            count_q <= count_d;
            irq_q   <= hit;
        end
    end

endmodule

// File: rtl/trim_counter.sv
module trim_counter
    import tcnt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [2:0]           rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    output logic [NUM_MATCH-1:0] match_irq
);

    ctrl_t                           ctrl_q;
    logic [TRIM_W-1:0]               trim_q;
    logic [TRIM_W-1:0]               trim_stage;
    logic                            trim_fire;
    logic [CNT_W-1:0]                load_stage;
    logic                            load_fire;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_nxt;
    logic [NUM_PEND-1:0]             pend_q;
    logic                            adv;
    logic [CNT_W-1:0]                count_q;

    tcnt_regs #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_regs (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .trim_q(trim_q), .trim_stage(trim_stage),
        .trim_fire(trim_fire), .load_stage(load_stage), .load_fire(load_fire),
        .match_q(match_q), .match_nxt(match_nxt), .pend_q(pend_q)
    );

    tcnt_prescale #(.TRIM_W(TRIM_W)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .ctrl_q(ctrl_q),
        .trim_q(trim_q), .trim_stage(trim_stage), .trim_fire(trim_fire),
        .adv(adv)
    );

    tcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .adv(adv), .load_fire(load_fire),
        .load_stage(load_stage), .match_nxt(match_nxt),
        .count_q(count_q), .irq_q(match_irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[1:0]                 = ctrl_q;
                rd_data[PEND_LSB +: NUM_PEND] = pend_q;
            end
            A_TRIM:  rd_data[TRIM_W-1:0] = trim_q;
            A_COUNT: rd_data = count_q;
            default: begin
                for (int m = 0; m < NUM_MATCH; m++) begin
                    if (rd_addr == slot_addr(P_MATCH0 + m)) rd_data = match_q[m];
                end
            end
        endcase
    end

    // R4: disabled and no load -> count frozen
    a_r4_hold : assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !load_fire) |=> $stable(count_q));
    // R6: bypass advances on every tick
    a_r6_bypass_step : assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.enable && ctrl_q.bypass && !load_fire)
            |=> (count_q == CNT_W'($past(count_q) + 1)));
    // R7: an applied load wins over an advance
    a_r7_load_wins : assert property (@(posedge clk) disable iff (rst)
        load_fire |=> (count_q == $past(load_stage)));
    // R8: all-ones rolls over to zero
    a_r8_wrap : assert property (@(posedge clk) disable iff (rst)
        (adv && !load_fire && (count_q == '1)) |=> (count_q == '0));

endmodule

// File: tb/tb_trim_counter.sv
`timescale 1ns/1ps
module tb_trim_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [2:0]  match_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    trim_counter dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .match_irq(match_irq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_cnt, s_load;
    logic [15:0] m_trim, s_trim, m_pre;
    logic [31:0] m_match [3];
    logic [31:0] s_match [3];
    logic        m_en, m_byp, s_en, s_byp;
    logic [5:0]  m_pend;
    logic [2:0]  m_irq;

    function automatic logic [2:0] bench_slot(input int k);
        return (k < 3) ? 3'(k) : 3'(k + 1);
    endfunction

    always @(posedge clk) begin
        logic [5:0]  ws, fi;
        logic        adv, ev;
        logic [31:0] nc, mn;
        if (rst) begin
            m_cnt = 0; s_load = 0; m_trim = 0; s_trim = 0; m_pre = 0;
            m_en = 0; m_byp = 0; s_en = 0; s_byp = 0; m_pend = 0; m_irq = 0;
            for (int i = 0; i < 3; i++) begin m_match[i] = 0; s_match[i] = 0; end
        end else begin
            for (int k = 0; k < 6; k++) begin
                ws[k] = wr_en && (wr_addr == bench_slot(k));
                fi[k] = tick && m_pend[k] && !ws[k];
            end
            adv = tick && m_en && (m_byp || m_pre == 0);
            if (fi[1]) m_pre = s_trim;
            else if (tick && m_en && !m_byp) m_pre = (m_pre == 0) ? m_trim : m_pre - 1;
            ev = fi[2] || adv;
            nc = fi[2] ? s_load : (adv ? m_cnt + 1 : m_cnt);
            for (int i = 0; i < 3; i++) begin
                mn = fi[3+i] ? s_match[i] : m_match[i];
                m_irq[i] = ev && (nc == mn);
                if (fi[3+i]) m_match[i] = s_match[i];
            end
            if (fi[0]) begin m_en = s_en; m_byp = s_byp; end
            if (fi[1]) m_trim = s_trim;
            m_cnt = nc;
            for (int k = 0; k < 6; k++) begin
                if (ws[k]) m_pend[k] = 1;
                else if (fi[k]) m_pend[k] = 0;
            end
            if (ws[0]) begin s_en = wr_data[0]; s_byp = wr_data[1]; end
            if (ws[1]) s_trim = wr_data[15:0];
            if (ws[2]) s_load = wr_data;
            for (int i = 0; i < 3; i++) if (ws[3+i]) s_match[i] = wr_data;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return {18'd0, m_pend, 6'd0, m_byp, m_en};
            3'd1: return {16'd0, m_trim};
            3'd3: return m_cnt;
            3'd4: return m_match[0];
            3'd5: return m_match[1];
            3'd6: return m_match[2];
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tag;
        case (rd_addr)
            3'd0: tag = "R2 ctrl/busy";
            3'd3: tag = "R5 count";
            3'd7: tag = "R10 spare";
            default: tag = "R1 register";
        endcase
        chk(tag, rd_data, model_rd(rd_addr));
        chk("R9 irq", {29'd0, match_irq}, {29'd0, m_irq});
    endtask

    // one clock: drive inputs now (at negedge), return at the following negedge
    task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
        wr_en = w; wr_addr = a; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 0; tick = 0;
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 32'd0, 1);
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        peek(3'd0, v); chk("R11 ctrl", v, 0);
        peek(3'd3, v); chk("R11 count", v, 0);
        chk("R11 irq", {29'd0, match_irq}, 0);

        // R2 staging, R3 transfer
        cyc(1, 3'd1, 32'd2, 0);
        peek(3'd0, v); chk("R2 trim busy", v, 32'h200);
        peek(3'd1, v); chk("R2 trim not applied", v, 0);
        ticks(1);
        peek(3'd0, v); chk("R3 busy cleared", v, 0);
        peek(3'd1, v); chk("R3 trim applied", v, 2);

        // R5 divide by trim+1
        cyc(1, 3'd0, 32'd1, 0); ticks(1);
        ticks(2); peek(3'd3, v); chk("R5 no advance yet", v, 0);
        ticks(1); peek(3'd3, v); chk("R5 advance on third", v, 1);

        // R6 bypass
        cyc(1, 3'd0, 32'd3, 0); ticks(1);
        ticks(4); peek(3'd3, v); chk("R6 bypass", v, 5);

        // R4 disable
        cyc(1, 3'd0, 32'd0, 0); ticks(1);
        ticks(3); peek(3'd3, v); chk("R4 frozen", v, 6);

        // R7 load, R8 wrap
        cyc(1, 3'd2, 32'hFFFF_FFFE, 0);
        peek(3'd0, v); chk("R2 load busy", v, 32'h400);
        ticks(1); peek(3'd3, v); chk("R7 loaded", v, 32'hFFFF_FFFE);
        cyc(1, 3'd0, 32'd3, 0); ticks(1);
        ticks(1); peek(3'd3, v); chk("R8 all ones", v, 32'hFFFF_FFFF);
        ticks(1); peek(3'd3, v); chk("R8 wrapped", v, 0);
        cyc(1, 3'd2, 32'd100, 0); ticks(1);
        peek(3'd3, v); chk("R7 load beats advance", v, 100);

        // R9 match pulses
        cyc(1, 3'd4, 32'd102, 0);
        cyc(1, 3'd5, 32'd101, 0);
        ticks(1); chk("R9 pulse m1 same-tick value", {29'd0, match_irq}, 32'd2);
        cyc(0, 3'd0, 32'd0, 0); chk("R9 pulse ends", {29'd0, match_irq}, 0);
        cyc(1, 3'd6, 32'd103, 0);
        cyc(1, 3'd0, 32'd0, 0);
        ticks(1); chk("R9 pulse m0", {29'd0, match_irq}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            ticks(1); chk("R9 no repeat", {29'd0, match_irq}, 0);
        end
        peek(3'd3, v); chk("R9 count held", v, 102);

        // R10 ignored writes
        cyc(1, 3'd3, 32'h55, 0); ticks(1);
        peek(3'd3, v); chk("R10 count addr ignored", v, 102);
        peek(3'd0, v); chk("R10 no busy for count addr", v, 0);
        cyc(1, 3'd7, 32'h77, 0); ticks(1);
        peek(3'd0, v); chk("R10 spare ignored", v, 0);
        cyc(1, 3'd0, 32'hFFFF_FFFC, 0); ticks(1);
        peek(3'd0, v); chk("R10 upper ctrl bits ignored", v, 0);

        // R3 write on a tick postpones
        cyc(1, 3'd1, 32'd5, 1);
        peek(3'd0, v); chk("R3 collision busy", v, 32'h200);
        peek(3'd1, v); chk("R3 collision trim kept", v, 2);
        ticks(1);
        peek(3'd1, v); chk("R3 trim after next tick", v, 5);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d;
            d = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 40));
            rd_addr = 3'($urandom_range(0, 7));
            cyc(($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)), d,
                ($urandom_range(0, 1) == 1));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule